// File: doc/BRIEF.md
# Relocating Index Address Adder

This block forms an indexed data address in a machine with 15-bit physical addresses split into eight 4096-word memory banks. It adds the 18-bit index register to an address operand and keeps the low 15 bits of the sum. The operand is either the 12-bit address field of an instruction or a 15-bit pointer word fetched during an indirect chain.

When the machine is not in extend mode, the number of the current bank is placed in the top three bits of the operand, so the indexed address is relative to that bank. When extend mode is on, an instruction field gets zero in those bits, so the sum is absolute. A pointer word is used with all 15 of its bits. The sum is taken either in two's complement, or in one's complement with an end-around carry. In one's complement, a result of all ones (minus zero) is replaced by zero before the address bits are taken.

A request is accepted in any cycle where `in_valid` is high. The address appears on registered outputs one clock later.

Top module: `idx_addr_adder`

## Requirements
- R1: During and right after synchronous reset, `out_valid` is 0 and `ea` is 0.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `ea` loads only after a cycle with `in_valid` high and otherwise keeps its value.
- R3: With `ones_mode`=0, `ea` is the low 15 bits of the 18-bit two's-complement sum of `index_reg` and the operand (example: index 777770 octal, operand 70 octal gives 60 octal).
- R4: With `ones_mode`=1, the carry out of the most significant bit of the 18-bit sum is added back in at bit 0 (example: index 777770, operand 70 gives 61 octal).
- R5: With `ones_mode`=1, an 18-bit sum of all ones is replaced by zero, so `ea` is 0 (example: index 777777, operand 0). With `ones_mode`=0 the same inputs give 77777.
- R6: With `src_defer`=0 and `extend`=0, the operand is `addr_word[11:0]` with `core[2:0]` in operand bits 14:12 (example: index 10100, field 30, core 2 gives 30130 octal).
- R7: With `src_defer`=0 and `extend`=1, operand bits 14:12 are zero and `core` has no effect (the same example gives 10130 octal).
- R8: With `src_defer`=1 and `extend`=0, the operand is `addr_word[11:0]` with `core` in bits 14:12. The pointer's bits 14:12 are ignored.
- R9: With `src_defer`=1 and `extend`=1, the operand is all of `addr_word[14:0]` and `core` has no effect.
- R10: Bits 17:15 of the 18-bit sum never reach `ea`. Field bits 14:12 of an instruction operand never affect `ea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| index_reg | input | 18 | Index register contents |
| addr_word | input | 15 | Instruction field (low 12 bits used) or pointer word |
| src_defer | input | 1 | 0: instruction field, 1: pointer word from a defer |
| core | input | 3 | Current memory bank number |
| extend | input | 1 | Extend mode flag |
| ones_mode | input | 1 | 1: one's-complement sum, 0: two's-complement |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| ea | output | 15 | Effective data address |

## Verification
A wrong operand select appears as an error in bits 14:12 of `ea` on the cycle after the request. These errors show up only for particular combinations of core number, extend flag and operand source, so every combination is driven. A lost end-around carry or a missing minus-zero fix makes `ea` off by exactly one, or all ones instead of zero. Both show up on the very next result when the sum wraps past 2^18, so the stimulus includes negative index values. A faulty load enable shows up as `ea` moving during an idle cycle.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;
  localparam int unsigned IDX_W   = 18;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned CORE_W  = ADDR_W - FIELD_W;

  typedef enum logic {
    SRC_FIELD = 1'b0,
    SRC_DEFER = 1'b1
  } opnd_src_e;

  typedef enum logic {
    ARITH_TWOS = 1'b0,
    ARITH_ONES = 1'b1
  } arith_e;
endpackage

// File: rtl/idx_operand_mux.sv
module idx_operand_mux #(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned FIELD_W = 12,
  localparam int unsigned CORE_W = ADDR_W - FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    word_i,
  input  idx_addr_pkg::opnd_src_e src_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic                 extend_i,
  output logic [ADDR_W-1:0]    opnd_o
);
  import idx_addr_pkg::*;

  logic [CORE_W-1:0] bank_bits;

  // Bank bits: current core when relative, pointer bits when an extended
  // defer, zero for an absolute instruction field.
  always_comb begin
    if (!extend_i)                 bank_bits = core_i;
    else if (src_i == SRC_DEFER)   bank_bits = word_i[ADDR_W-1:FIELD_W];
    else                           bank_bits = '0;
  end

  assign opnd_o = {bank_bits, word_i[FIELD_W-1:0]};

  // Low field bits always pass through untouched.
  p_field_pass_r6: assert property (@(posedge clk) disable iff (rst)
    opnd_o[FIELD_W-1:0] == word_i[FIELD_W-1:0]);

  // Absolute instruction field has zero bank bits.
  p_abs_field_r7: assert property (@(posedge clk) disable iff (rst)
    (extend_i && src_i == SRC_FIELD) |-> opnd_o[ADDR_W-1:FIELD_W] == '0);
endmodule

// File: rtl/idx_ones_twos_add.sv
module idx_ones_twos_add #(
  parameter int unsigned IDX_W  = 18,
  parameter int unsigned ADDR_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [ADDR_W-1:0]   opnd_i,
  input  idx_addr_pkg::arith_e mode_i,
  output logic [IDX_W-1:0]    sum_o
);
  import idx_addr_pkg::*;

  localparam int unsigned PAD_W = IDX_W - ADDR_W;

  logic [IDX_W-1:0] opnd_ext;
  logic [IDX_W:0]   raw;
  logic [IDX_W-1:0] wrapped;

  assign opnd_ext = {{PAD_W{1'b0}}, opnd_i};
  assign raw      = {1'b0, idx_i} + {1'b0, opnd_ext};

  // End-around carry: the carry never overflows a second time, since the
  // low part is at most all-ones minus one when a carry occurs.
  assign wrapped  = raw[IDX_W-1:0] + {{(IDX_W-1){1'b0}}, raw[IDX_W]};

  always_comb begin
    if (mode_i == ARITH_TWOS)   sum_o = raw[IDX_W-1:0];
    else if (&wrapped)          sum_o = '0;
    else                        sum_o = wrapped;
  end

  // One's-complement result is never minus zero.
  p_no_negzero_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == ARITH_ONES) |-> !(&sum_o));

  // One's-complement result lies within one of the plain modular sum, or is
  // the cleaned-up zero.
  p_ones_near_twos_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == ARITH_ONES) |->
      (sum_o == IDX_W'(idx_i + opnd_ext) ||
       sum_o == IDX_W'(idx_i + opnd_ext + 1'b1) || sum_o == '0));
endmodule

// File: rtl/idx_addr_adder.sv
module idx_addr_adder #(
  parameter int unsigned IDX_W   = 18,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned FIELD_W = 12,
  localparam int unsigned CORE_W = ADDR_W - FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IDX_W-1:0]   index_reg,
  input  logic [ADDR_W-1:0]  addr_word,
  input  logic               src_defer,
  input  logic [CORE_W-1:0]  core,
  input  logic               extend,
  input  logic               ones_mode,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  ea
);
  import idx_addr_pkg::*;

  logic [ADDR_W-1:0] opnd;
  logic [IDX_W-1:0]  sum;

  idx_operand_mux #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .word_i   (addr_word),
    .src_i    (opnd_src_e'(src_defer)),
    .core_i   (core),
    .extend_i (extend),
    .opnd_o   (opnd)
  );

  idx_ones_twos_add #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_add (
    .clk    (clk),
    .rst    (rst),
    .idx_i  (index_reg),
    .opnd_i (opnd),
    .mode_i (arith_e'(ones_mode)),
    .sum_o  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) ea <= sum[ADDR_W-1:0];
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(ea)));

  // Zero index with an absolute instruction field yields bank 0.
  p_abs_bank_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && extend && !src_defer && index_reg == '0) |=>
      ea[ADDR_W-1:FIELD_W] == '0);

  // Zero index with a relative operand lands in the current bank.
  p_rel_bank_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !extend && index_reg == '0) |=>
      ea[ADDR_W-1:FIELD_W] == $past(core));
endmodule

// File: tb/tb_idx_addr_adder.sv
`timescale 1ns/1ps
module tb_idx_addr_adder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [17:0] index_reg;
  logic [14:0] addr_word;
  logic        src_defer;
  logic [2:0]  core;
  logic        extend;
  logic        ones_mode;
  logic        out_valid;
  logic [14:0] ea;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  idx_addr_adder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .index_reg(index_reg),
    .addr_word(addr_word), .src_defer(src_defer), .core(core),
    .extend(extend), .ones_mode(ones_mode), .out_valid(out_valid), .ea(ea)
  );

  function automatic logic [14:0] model(input logic [17:0] x, input logic [14:0] w,
                                       input logic d, input logic [2:0] c,
                                       input logic e, input logic o);
    logic [17:0] a;
    logic [18:0] s;
    logic [17:0] r;
    if (!e)     a = {3'b0, c, w[11:0]};
    else if (d) a = {3'b0, w};
    else        a = {6'b0, w[11:0]};
    s = {1'b0, x} + {1'b0, a};
    if (o) begin
      r = s[17:0] + {17'b0, s[18]};
      if (r == 18'o777777) r = '0;
    end else r = s[17:0];
    return r[14:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [17:0] x, input logic [14:0] w,
                     input logic d, input logic [2:0] c, input logic e, input logic o);
    @(negedge clk);
    in_valid = 1'b1; index_reg = x; addr_word = w; src_defer = d;
    core = c; extend = e; ones_mode = o;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, {17'b0, ea}, {17'b0, model(x, w, d, c, e, o)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] held;
    void'($urandom(32'd4711));
    rst = 1'b1; in_valid = 1'b0; index_reg = '0; addr_word = '0;
    src_defer = 1'b0; core = '0; extend = 1'b0; ones_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, out_valid}, 32'd0);
    check("R1 ea", {17'b0, ea}, 32'd0);
    rst = 1'b0;

    run("R3", 18'o777770, 15'o70, 1'b0, 3'd0, 1'b0, 1'b0);
    check("R3 value", {17'b0, ea}, 32'o60);
    run("R4", 18'o777770, 15'o70, 1'b0, 3'd0, 1'b0, 1'b1);
    check("R4 value", {17'b0, ea}, 32'o61);
    run("R5", 18'o777777, 15'o0, 1'b0, 3'd0, 1'b1, 1'b1);
    check("R5 value", {17'b0, ea}, 32'o0);
    run("R5 twos", 18'o777777, 15'o0, 1'b0, 3'd0, 1'b1, 1'b0);
    check("R5 twos value", {17'b0, ea}, 32'o77777);
    run("R6", 18'o10100, 15'o30, 1'b0, 3'd2, 1'b0, 1'b0);
    check("R6 value", {17'b0, ea}, 32'o30130);
    run("R7", 18'o10100, 15'o30, 1'b0, 3'd2, 1'b1, 1'b0);
    check("R7 value", {17'b0, ea}, 32'o10130);
    run("R10 field top ignored", 18'o0, 15'o70030, 1'b0, 3'd5, 1'b1, 1'b0);
    check("R10 field value", {17'b0, ea}, 32'o30);
    run("R8", 18'o0, 15'o62345, 1'b1, 3'd3, 1'b0, 1'b1);
    check("R8 value", {17'b0, ea}, 32'o32345);
    run("R9", 18'o10100, 15'o11234, 1'b1, 3'd2, 1'b1, 1'b0);
    check("R9 value", {17'b0, ea}, 32'o21334);
    run("R10 top discard", 18'o700000, 15'o1234, 1'b1, 3'd0, 1'b1, 1'b0);
    check("R10 top value", {17'b0, ea}, 32'o1234);

    held = ea;
    @(negedge clk);
    in_valid = 1'b0; index_reg = 18'o123456; addr_word = 15'o7777; core = 3'd7;
    @(negedge clk);
    check("R2 idle valid", {31'b0, out_valid}, 32'd0);
    check("R2 idle hold", {17'b0, ea}, {17'b0, held});

    for (int i = 0; i < 300; i++) begin
      logic [17:0] x;
      x = 18'($urandom);
      if (i % 4 == 0) x = x | 18'o700000;
      run((i % 2) ? "R4 rand" : "R3 rand", x, 15'($urandom), 1'($urandom),
          3'($urandom), 1'($urandom), 1'(i % 2));
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset", {17'b0, ea}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule